// File: doc/BRIEF.md
# Daisy-Chained Converter Readout Controller

This block is the host side of a serial link to a chain of four-channel integrating converters. All of them share one gated data clock, and each converter's serial input is fed from the serial output of the one before it. When the active-low data-ready strobe falls, the controller clocks out one continuous burst. The burst length is the chain length times the per-device share: 80 bits when the wide format is selected and 64 bits otherwise. The controller then stops clocking exactly at the end of the chain, so the stream never wraps back to the first result.

Incoming bits are assembled into per-channel words. Each word is handed downstream on a valid/ready port and tagged with its device and channel index. Backpressure holds the data clock only at word boundaries, never inside a word. A done pulse marks the acceptance of the last word.

The readout window is tied to a conversion-toggle signal, in one of two scheduling modes:
- In before-toggle mode, a burst must complete a guard time before the next toggle is due.
- In after-toggle mode, a burst waits a programmed delay after a toggle edge and must end before the next data-ready strobe.

A burst that cannot fit in its window is abandoned without emitting a partial word, and a sticky overrun flag is raised.

Top module: `daisy_readout`

## Requirements
- R1: After reset, the data clock is low, no word is valid, no done pulse is given and the overrun flag is clear.
- R2: In before-toggle mode, no data-clock edge occurs until the data-ready input falls (a 1-to-0 change sampled on the system clock).
- R3: A completed burst gives exactly cfgChainLen×80 rising data-clock edges with cfgWide=1 and cfgChainLen×64 with cfgWide=0. No further edges follow, even though the chain would keep presenting data.
- R4: Each device contributes four words. The words are emitted in stream order: device 0 channels 0,1,2,3 (channel 0 first), then device 1, and so on. The first bit received is each word's most significant bit. Wide words carry 20 bits. Narrow words carry 16 bits in wordData[15:0], with wordData[19:16] zero. wordDev and wordChan give the device and channel index.
- R5: The data clock idles low. Serial input is sampled as the data clock rises. The high and low phases each last cfgClkDiv system-clock cycles.
- R6: In before-toggle mode, the budget at data-ready is checked first. The required time is cfgChainLen×(80 or 64)×2×cfgClkDiv cycles. The limit is cfgPeriod−cfgGuardBefore cycles after the last toggle edge. If the cycles already elapsed since that edge plus the required time exceed the limit, no burst starts and the overrun flag sets.
- R7: In before-toggle mode, if a started burst reaches the limit of R6 (for example because it is stalled), clocking stops at once and the overrun flag sets. The partially received word is never emitted.
- R8: In after-toggle mode, data-ready only arms the controller. The first data-clock rise comes no sooner than cfgDelayAfter+cfgClkDiv cycles after the following conversion-toggle edge (either direction).
- R9: In after-toggle mode, a new data-ready fall while the controller is waiting or clocking abandons the burst. Clocking stops, no partial word is emitted, and the overrun flag sets.
- R10: A valid word holds its data and tags until accepted. No rising data-clock edge occurs while a word is waiting, so stalls fall only between words.
- R11: burstDone pulses for one cycle after the final word of a completed burst is accepted. An abandoned burst gives no pulse.
- R12: The overrun flag, once set, stays set until reset, including across later successful bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgChainLen | input | DEV_CNT_W | Number of chained devices, 1..MAX_DEV |
| cfgWide | input | 1 | 1: 20-bit results (80 bits per device); 0: 16-bit results (64 bits per device) |
| cfgModeAfter | input | 1 | 0: read before the toggle; 1: read after the toggle |
| cfgClkDiv | input | DIV_W | Data-clock half period in system cycles, at least 1 |
| cfgPeriod | input | TIME_W | Expected cycles between conversion-toggle edges |
| cfgGuardBefore | input | TIME_W | Cycles that must remain before the next toggle |
| cfgDelayAfter | input | TIME_W | Cycles to wait after a toggle edge before reading |
| dataReadyN | input | 1 | Active-low data-ready strobe |
| convToggle | input | 1 | Conversion-toggle level; each change is an edge |
| sdi | input | 1 | Serial data from the end of the chain |
| sclk | output | 1 | Gated data clock, idles low |
| wordValid | output | 1 | Output word valid |
| wordReady | input | 1 | Downstream accepts the word |
| wordData | output | 20 | Result word, zero-extended in narrow format |
| wordDev | output | DEV_IDX_W | Device index of the word |
| wordChan | output | 2 | Channel index of the word |
| burstDone | output | 1 | One-cycle pulse when a burst has been fully accepted |
| overrunErr | output | 1 | Sticky window overrun flag |

## Verification
The bench uses the default parameters: up to eight devices, an 8-bit divider and 24-bit window timers. It programs chains of one to three devices with divider ratios of one and two, so every complete burst and every window violation happens within a few hundred cycles. A behavioural chain model shifts a computed, wrapping stream on each falling data-clock edge. An exact stop point, the bit order, the zero extension of narrow words and the stall-free-inside-a-word rule can therefore be observed directly. Small period and guard values push the budget check and the stalled-burst deadline across their limits, and a second data-ready strobe exercises the abort in after-toggle mode.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int RES_W = 20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_TOG, ST_DELAY, ST_GAP, ST_LOW, ST_HIGH, ST_FLUSH
  } rdoState_t;

  typedef struct packed {
    logic capture;
    logic load;
  } dpCtl_t;
endpackage

// File: rtl/rdo_window.sv
module rdo_window #(
  parameter int TIME_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convToggle,
  input  logic [TIME_W-1:0] cfgPeriod,
  input  logic [TIME_W-1:0] cfgGuardBefore,
  input  logic [TIME_W-1:0] cfgDelayAfter,
  input  logic [TIME_W-1:0] required,
  output logic              togEdge,
  output logic              delayMet,
  output logic              deadlineHit,
  output logic              fitsWindow
);
  localparam logic [TIME_W-1:0] MAX_COUNT = '1;

  logic              togPrev;
  logic [TIME_W-1:0] sinceTog;
  logic [TIME_W-1:0] limit;

  assign togEdge = convToggle ^ togPrev;
  assign limit = (cfgPeriod > cfgGuardBefore) ? (cfgPeriod - cfgGuardBefore) : '0;
  assign delayMet = sinceTog >= cfgDelayAfter;
  assign deadlineHit = sinceTog >= limit;
  assign fitsWindow = ({1'b0, sinceTog} + {1'b0, required}) <= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      togPrev  <= 1'b0;
      sinceTog <= '0;
    end else begin
      togPrev <= convToggle;
      if (togEdge) sinceTog <= '0;
      else if (sinceTog != MAX_COUNT) sinceTog <= sinceTog + 1'b1;
    end
  end
endmodule

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
  import readout_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int TIME_W    = 24,
  parameter int DEV_CNT_W = 4,
  parameter int DEV_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DEV_CNT_W-1:0] cfgChainLen,
  input  logic                 cfgWide,
  input  logic                 cfgModeAfter,
  input  logic [DIV_W-1:0]     cfgClkDiv,
  input  logic                 dataReadyN,
  input  logic                 togEdge,
  input  logic                 delayMet,
  input  logic                 deadlineHit,
  input  logic                 fitsWindow,
  input  logic                 slotValid,
  output logic [TIME_W-1:0]    required,
  output dpCtl_t               dpCtl,
  output logic [DEV_IDX_W-1:0] tagDev,
  output logic [1:0]           tagChan,
  output logic                 sclk,
  output logic                 burstDone,
  output logic                 overrunErr
);
  rdoState_t          state;
  logic               drPrev;
  logic               drFall;
  logic [DIV_W-1:0]   phase;
  logic               phaseDone;
  logic [4:0]         bitCnt;
  logic               lastBit;
  logic               lastWord;
  logic               bursting;
  logic               abortNow;
  logic [6:0]         devBits;

  assign drFall    = drPrev & ~dataReadyN;
  assign devBits   = cfgWide ? 7'd80 : 7'd64;
  assign required  = TIME_W'(cfgChainLen) * TIME_W'(devBits) * TIME_W'(cfgClkDiv) * TIME_W'(2);
  assign phaseDone = ({1'b0, phase} + 1'b1) >= {1'b0, cfgClkDiv};
  assign lastBit   = bitCnt == (cfgWide ? 5'd19 : 5'd15);
  assign lastWord  = (tagChan == 2'd3) && (DEV_CNT_W'(tagDev) == cfgChainLen - DEV_CNT_W'(1));
  assign bursting  = (state == ST_GAP) || (state == ST_LOW) || (state == ST_HIGH);
  assign abortNow  = bursting && (cfgModeAfter ? drFall : deadlineHit);

  always_comb begin
    dpCtl.capture = (state == ST_LOW) && phaseDone && !abortNow;
    dpCtl.load    = (state == ST_HIGH) && phaseDone && lastBit && !abortNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      drPrev     <= 1'b1;
      phase      <= '0;
      bitCnt     <= '0;
      tagDev     <= '0;
      tagChan    <= '0;
      sclk       <= 1'b0;
      burstDone  <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      drPrev    <= dataReadyN;
      burstDone <= 1'b0;
      if (abortNow) begin
        sclk       <= 1'b0;
        overrunErr <= 1'b1;
        state      <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (drFall) begin
              bitCnt  <= '0;
              tagDev  <= '0;
              tagChan <= '0;
              if (cfgModeAfter) state <= ST_WAIT_TOG;
              else if (fitsWindow) state <= ST_GAP;
              else overrunErr <= 1'b1;
            end
          end
          ST_WAIT_TOG: begin
            if (drFall) begin
              overrunErr <= 1'b1;
              state      <= ST_IDLE;
            end else if (togEdge) begin
              state <= ST_DELAY;
            end
          end
          ST_DELAY: begin
            if (drFall) begin
              overrunErr <= 1'b1;
              state      <= ST_IDLE;
            end else if (delayMet) begin
              state <= ST_GAP;
            end
          end
          ST_GAP: begin
            if (!slotValid) begin
              phase <= '0;
              state <= ST_LOW;
            end
          end
          ST_LOW: begin
            if (phaseDone) begin
              phase <= '0;
              sclk  <= 1'b1;
              state <= ST_HIGH;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          ST_HIGH: begin
            if (phaseDone) begin
              phase <= '0;
              sclk  <= 1'b0;
              if (lastBit) begin
                bitCnt <= '0;
                if (lastWord) begin
                  state <= ST_FLUSH;
                end else begin
                  tagChan <= tagChan + 1'b1;
                  if (tagChan == 2'd3) tagDev <= tagDev + 1'b1;
                  state <= ST_GAP;
                end
              end else begin
                bitCnt <= bitCnt + 1'b1;
                state  <= ST_LOW;
              end
            end else begin
              phase <= phase + 1'b1;
            end
          end
          ST_FLUSH: begin
            if (!slotValid) begin
              burstDone <= 1'b1;
              state     <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |=> overrunErr);

  assert_done_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> !slotValid);

  assert_word_start_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclk) && bitCnt == 5'd0) |-> !slotValid);

  assert_idle_clock_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_WAIT_TOG || state == ST_DELAY) |-> !sclk);
endmodule

// File: rtl/rdo_datapath.sv
module rdo_datapath
  import readout_pkg::*;
#(
  parameter int DEV_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               dpCtl,
  input  logic                 sdi,
  input  logic                 cfgWide,
  input  logic [DEV_IDX_W-1:0] tagDev,
  input  logic [1:0]           tagChan,
  input  logic                 wordReady,
  output logic                 wordValid,
  output logic [RES_W-1:0]     wordData,
  output logic [DEV_IDX_W-1:0] wordDev,
  output logic [1:0]           wordChan
);
  logic [RES_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      wordValid <= 1'b0;
      wordData  <= '0;
      wordDev   <= '0;
      wordChan  <= '0;
    end else begin
      if (dpCtl.capture) shiftReg <= {shiftReg[RES_W-2:0], sdi};
      if (dpCtl.load) begin
        wordValid <= 1'b1;
        wordData  <= cfgWide ? shiftReg : {4'b0, shiftReg[15:0]};
        wordDev   <= tagDev;
        wordChan  <= tagChan;
      end else if (wordValid && wordReady) begin
        wordValid <= 1'b0;
      end
    end
  end

  assert_load_into_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.load |-> !wordValid);

  assert_hold_until_taken_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> (wordValid && $stable(wordData) && $stable(wordDev) && $stable(wordChan)));
endmodule

// File: rtl/daisy_readout.sv
module daisy_readout
  import readout_pkg::*;
#(
  parameter int MAX_DEV   = 8,
  parameter int DIV_W     = 8,
  parameter int TIME_W    = 24,
  localparam int DEV_CNT_W = $clog2(MAX_DEV + 1),
  localparam int DEV_IDX_W = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DEV_CNT_W-1:0] cfgChainLen,
  input  logic                 cfgWide,
  input  logic                 cfgModeAfter,
  input  logic [DIV_W-1:0]     cfgClkDiv,
  input  logic [TIME_W-1:0]    cfgPeriod,
  input  logic [TIME_W-1:0]    cfgGuardBefore,
  input  logic [TIME_W-1:0]    cfgDelayAfter,
  input  logic                 dataReadyN,
  input  logic                 convToggle,
  input  logic                 sdi,
  output logic                 sclk,
  output logic                 wordValid,
  input  logic                 wordReady,
  output logic [RES_W-1:0]     wordData,
  output logic [DEV_IDX_W-1:0] wordDev,
  output logic [1:0]           wordChan,
  output logic                 burstDone,
  output logic                 overrunErr
);
  logic                 togEdge;
  logic                 delayMet;
  logic                 deadlineHit;
  logic                 fitsWindow;
  logic [TIME_W-1:0]    required;
  dpCtl_t               dpCtl;
  logic [DEV_IDX_W-1:0] tagDev;
  logic [1:0]           tagChan;

  rdo_window #(.TIME_W(TIME_W)) uWindow (
    .clk(clk), .rstN(rstN), .convToggle(convToggle),
    .cfgPeriod(cfgPeriod), .cfgGuardBefore(cfgGuardBefore), .cfgDelayAfter(cfgDelayAfter),
    .required(required), .togEdge(togEdge), .delayMet(delayMet),
    .deadlineHit(deadlineHit), .fitsWindow(fitsWindow)
  );

  rdo_ctrl #(.DIV_W(DIV_W), .TIME_W(TIME_W), .DEV_CNT_W(DEV_CNT_W), .DEV_IDX_W(DEV_IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgChainLen(cfgChainLen), .cfgWide(cfgWide),
    .cfgModeAfter(cfgModeAfter), .cfgClkDiv(cfgClkDiv), .dataReadyN(dataReadyN),
    .togEdge(togEdge), .delayMet(delayMet), .deadlineHit(deadlineHit),
    .fitsWindow(fitsWindow), .slotValid(wordValid), .required(required),
    .dpCtl(dpCtl), .tagDev(tagDev), .tagChan(tagChan), .sclk(sclk),
    .burstDone(burstDone), .overrunErr(overrunErr)
  );

  rdo_datapath #(.DEV_IDX_W(DEV_IDX_W)) uData (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .sdi(sdi), .cfgWide(cfgWide),
    .tagDev(tagDev), .tagChan(tagChan), .wordReady(wordReady),
    .wordValid(wordValid), .wordData(wordData), .wordDev(wordDev), .wordChan(wordChan)
  );
endmodule

// File: tb/sim_daisy_readout.sv
module sim_daisy_readout;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgChainLen = 4'd1;
  logic        cfgWide = 1'b1;
  logic        cfgModeAfter = 1'b0;
  logic [7:0]  cfgClkDiv = 8'd1;
  logic [23:0] cfgPeriod = 24'd100000;
  logic [23:0] cfgGuardBefore = 24'd100;
  logic [23:0] cfgDelayAfter = 24'd0;
  logic        dataReadyN = 1'b1;
  logic        convToggle = 1'b0;
  logic        sdi;
  logic        sclk;
  logic        wordValid;
  logic        wordReady = 1'b1;
  logic [19:0] wordData;
  logic [2:0]  wordDev;
  logic [1:0]  wordChan;
  logic        burstDone;
  logic        overrunErr;

  int checks = 0;
  int failures = 0;
  int streamIdx = 0;
  int rises = 0;
  int wordsN = 0;
  int doneCnt = 0;
  int viol = 0;
  int highTime = 0;
  int riseTime = 0;
  int curN = 1;
  bit curWide = 1'b1;
  bit bpMode = 1'b0;
  int bpCnt = 0;
  logic [19:0] gotData [0:31];
  int gotDev [0:31];
  int gotChan [0:31];

  always #2 clk = ~clk;

  daisy_readout u0 (
    .clk(clk), .rstN(rstN), .cfgChainLen(cfgChainLen), .cfgWide(cfgWide),
    .cfgModeAfter(cfgModeAfter), .cfgClkDiv(cfgClkDiv), .cfgPeriod(cfgPeriod),
    .cfgGuardBefore(cfgGuardBefore), .cfgDelayAfter(cfgDelayAfter),
    .dataReadyN(dataReadyN), .convToggle(convToggle), .sdi(sdi), .sclk(sclk),
    .wordValid(wordValid), .wordReady(wordReady), .wordData(wordData),
    .wordDev(wordDev), .wordChan(wordChan), .burstDone(burstDone), .overrunErr(overrunErr)
  );

  function automatic logic [19:0] expWord(int dev, int ch, bit wide);
    logic [31:0] v;
    v = 32'hA5C3F ^ (dev * 32'h1357) ^ (ch * 32'h02F1) ^ (32'(ch) << 16);
    return wide ? v[19:0] : {4'b0, v[15:0]};
  endfunction

  function automatic logic bitAt(int idx, int n, bit wide);
    int w;
    int total;
    int k;
    logic [19:0] word;
    w = wide ? 20 : 16;
    total = n * 4 * w;
    k = idx % total;
    word = expWord((k / w) / 4, (k / w) % 4, wide);
    return word[w - 1 - (k % w)];
  endfunction

  assign sdi = bitAt(streamIdx, curN, curWide);

  always @(negedge sclk) begin
    streamIdx++;
    highTime = $time - riseTime;
  end

  always @(posedge sclk) begin
    rises++;
    riseTime = $time;
    if (wordValid) viol++;
  end

  always @(negedge clk) begin
    if (wordValid && wordReady && wordsN < 32) begin
      gotData[wordsN] = wordData;
      gotDev[wordsN] = wordDev;
      gotChan[wordsN] = wordChan;
      wordsN++;
    end
    if (burstDone) doneCnt++;
  end

  always @(posedge clk) begin
    if (bpMode) begin
      #1;
      bpCnt++;
      wordReady = (bpCnt % 3) == 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkRange(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clearStats();
    streamIdx = 0;
    rises = 0;
    wordsN = 0;
    doneCnt = 0;
    viol = 0;
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rstN = 1'b0;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    clearStats();
  endtask

  task automatic pulseReady();
    @(posedge clk); #1;
    dataReadyN = 1'b0;
    waitCycles(3);
    dataReadyN = 1'b1;
  endtask

  task automatic toggleConv();
    @(posedge clk); #1;
    convToggle = ~convToggle;
  endtask

  task automatic waitDone(int maxCycles);
    for (int i = 0; i < maxCycles && doneCnt == 0; i++) waitCycles(1);
  endtask

  task automatic checkWords(string tag, int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (gotData[i] != expWord(i / 4, i % 4, curWide) || gotDev[i] != i / 4 || gotChan[i] != i % 4) begin
        bad++;
        $display("FAIL %s word %0d actual=%h dev=%0d ch=%0d expected=%h dev=%0d ch=%0d", tag, i,
                 gotData[i], gotDev[i], gotChan[i], expWord(i / 4, i % 4, curWide), i / 4, i % 4);
      end
    end
    checks++;
    if (bad != 0) failures++;
  endtask

  task automatic setCfg(int n, bit wide, bit modeAfter, int div);
    curN = n;
    curWide = wide;
    cfgChainLen = 4'(n);
    cfgWide = wide;
    cfgModeAfter = modeAfter;
    cfgClkDiv = 8'(div);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 wordValid", int'(wordValid), 0);
    chk("R1 burstDone", int'(burstDone), 0);
    chk("R1 overrunErr", int'(overrunErr), 0);
  endtask

  task automatic testBeforeWide();
    doReset();
    setCfg(2, 1'b1, 1'b0, 2);
    cfgPeriod = 24'd100000;
    cfgGuardBefore = 24'd100;
    toggleConv();
    waitCycles(30);
    chk("R2 no clock before ready", rises, 0);
    pulseReady();
    waitDone(2000);
    waitCycles(50);
    chk("R3 wide rises", rises, 160);
    chk("R4 wide word count", wordsN, 8);
    checkWords("R4 wide words", 8);
    chk("R11 done once", doneCnt, 1);
    chk("R5 high phase ns", highTime, 8);
    chk("R5 idle low", int'(sclk), 0);
    chk("R6 fitting burst no error", int'(overrunErr), 0);
  endtask

  task automatic testBeforeNarrow();
    doReset();
    setCfg(3, 1'b0, 1'b0, 1);
    toggleConv();
    pulseReady();
    waitDone(2000);
    waitCycles(30);
    chk("R3 narrow rises", rises, 192);
    chk("R4 narrow word count", wordsN, 12);
    checkWords("R4 narrow words", 12);
    chk("R5 high phase div1 ns", highTime, 4);
    chk("R11 narrow done", doneCnt, 1);
  endtask

  task automatic testBackpressure();
    doReset();
    setCfg(2, 1'b1, 1'b0, 1);
    toggleConv();
    bpMode = 1'b1;
    pulseReady();
    waitDone(3000);
    bpMode = 1'b0;
    @(posedge clk); #1;
    wordReady = 1'b1;
    waitCycles(20);
    chk("R10 word count under stall", wordsN, 8);
    checkWords("R10 words under stall", 8);
    chk("R10 no rise while word waits", viol, 0);
    chk("R3 rises under stall", rises, 160);
  endtask

  task automatic testPrecheck();
    doReset();
    setCfg(2, 1'b1, 1'b0, 2);
    cfgPeriod = 24'd500;
    cfgGuardBefore = 24'd10;
    toggleConv();
    pulseReady();
    waitCycles(60);
    chk("R6 overrun on short window", int'(overrunErr), 1);
    chk("R6 no clocking", rises, 0);
    chk("R6 no words", wordsN, 0);
  endtask

  task automatic testStallAbort();
    doReset();
    setCfg(1, 1'b1, 1'b0, 2);
    cfgPeriod = 24'd400;
    cfgGuardBefore = 24'd20;
    @(posedge clk); #1;
    wordReady = 1'b0;
    toggleConv();
    pulseReady();
    waitCycles(450);
    chk("R7 overrun after deadline", int'(overrunErr), 1);
    chk("R7 clocking stopped at word edge", rises, 20);
    chk("R7 clock low", int'(sclk), 0);
    wordReady = 1'b1;
    waitCycles(20);
    chk("R7 only whole word", wordsN, 1);
    checkWords("R7 first word", 1);
    chk("R11 no done on abort", doneCnt, 0);
    cfgPeriod = 24'd100000;
    cfgGuardBefore = 24'd100;
  endtask

  task automatic testAfter();
    int cyc;
    doReset();
    setCfg(2, 1'b0, 1'b1, 1);
    cfgDelayAfter = 24'd30;
    pulseReady();
    waitCycles(20);
    chk("R8 wait for toggle", rises, 0);
    toggleConv();
    cyc = 0;
    while (rises == 0 && cyc < 200) begin
      @(posedge clk);
      cyc++;
    end
    chkRange("R8 delay before first rise", cyc, 31, 37);
    waitDone(2000);
    waitCycles(20);
    chk("R8 after-mode rises", rises, 128);
    checkWords("R8 after-mode words", 8);
    chk("R11 after-mode done", doneCnt, 1);
  endtask

  task automatic testAfterAbort();
    int snap;
    clearStats();
    pulseReady();
    toggleConv();
    for (int i = 0; i < 500 && rises < 10; i++) waitCycles(1);
    pulseReady();
    waitCycles(5);
    snap = rises;
    waitCycles(100);
    chk("R9 clocking stopped", rises, snap);
    chkRange("R9 abandoned early", snap, 10, 15);
    chk("R9 overrun", int'(overrunErr), 1);
    chk("R9 no partial word", wordsN, 0);
    chk("R11 no done on abort", doneCnt, 0);
    clearStats();
    pulseReady();
    toggleConv();
    waitDone(2000);
    waitCycles(10);
    chk("R12 later burst completes", wordsN, 8);
    chk("R12 flag still set", int'(overrunErr), 1);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testBeforeWide();
    testBeforeNarrow();
    testBackpressure();
    testPrecheck();
    testStallAbort();
    testAfter();
    testAfterAbort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule